// File: doc/BRIEF.md
# Pipelined Cascadable Parity Checker

This block checks the parity of a 10-bit data word whose parity bit is delivered one clock later than the word. The word is registered on arrival. In the next cycle the parity bit is combined with the registered word through an XOR tree. The verdict is written to an error register, so the active-low error flag shows the result one clock after the parity bit.

A shared parity line serves two purposes. With the sum-output enable held high, the block reads the line. It acts as an odd/even selector when the block is used alone, and it carries a partial sum from an upstream checker when two blocks are chained. With the sum-output enable low, the block drives its own partial sum onto the line for a downstream checker. The line is modelled as separate in, out and drive-enable signals. An active-low capture enable decides whether the error register takes a new verdict or keeps its old one.

Top module: `cascade_parity_chk`

## Requirements
- R1: A word on `data_i` is registered at a rising edge. The parity check in the following cycle uses that registered word, whatever `data_i` carries during the cycle of the parity bit.
- R2: The verdict for a parity bit presented in cycle t appears on `err_no` only after the rising edge that ends cycle t. During cycle t, `err_no` keeps its previous value.
- R3: With `sum_oe_ni`=1 and `par_io_i`=0 (even parity), a capture sets `err_no`=0 exactly when the number of ones over the 10 registered bits plus `par_i` is odd. Otherwise it sets `err_no`=1.
- R4: With `sum_oe_ni`=1 and `par_io_i`=1 (odd parity), a capture sets `err_no`=0 exactly when that number of ones is even.
- R5: With `sum_oe_ni`=0, `par_io_oe`=1 and `par_io_o` equals the XOR of the 10 registered bits and `par_i`, in the same cycle as `par_i`.
- R6: With `sum_oe_ni`=1, `par_io_oe`=0.
- R7: As the downstream device of a chained pair (`sum_oe_ni`=1, `par_io_i` = upstream partial sum), a capture flags an error exactly when the upstream sum XOR the local word XOR `par_i` is 1.
- R8: While `cap_en_ni`=1 at a rising edge, `err_no` keeps its value.
- R9: With `sum_oe_ni`=0 and `cap_en_ni`=0, a capture writes the no-error state (`err_no`=1).
- R10: Reset sets `err_no`=1 and clears the word register. Directly after reset with `sum_oe_ni`=0, `par_io_o` equals `par_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| data_i | input | 10 | Data word covered by parity |
| par_i | input | 1 | Parity bit, one cycle after its word |
| cap_en_ni | input | 1 | Active-low error-capture enable |
| sum_oe_ni | input | 1 | Active-low partial-sum output enable |
| par_io_i | input | 1 | Value read from the shared parity line |
| par_io_o | output | 1 | Partial sum driven onto the shared line |
| par_io_oe | output | 1 | Drive enable for the shared line |
| err_no | output | 1 | Registered error flag, low on error |

## Verification
The hardest situation to reach is a mismatch between the word that is checked and the word present at the ports. The parity bit belongs to the previous word, while `data_i` already carries something else. The bench follows every word with a copy that has bit 0 flipped, which always has the opposite parity. If the design checked the live input instead of the registered word, every verdict would invert. A second awkward case is holding a stale error while good parity arrives with capture disabled, and then seeing it clear once capture is re-enabled.

// File: rtl/cpc_pkg.sv
package cpc_pkg;
  typedef enum logic {
    MODE_CHECK  = 1'b0,
    MODE_EXPORT = 1'b1
  } cpc_mode_e;
endpackage

// File: rtl/cpc_word_pipe.sv
module cpc_word_pipe #(
  parameter int unsigned WORD_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] word_q, word_d;
  logic              seen_q;

  always_comb begin
    word_d = word_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      seen_q <= 1'b0;
    end else begin
      word_q <= word_d;
      seen_q <= 1'b1;
    end
  end

  assign word_o = word_q;

  AST_WORD_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> (word_o == $past(word_i))); // R1
endmodule

// File: rtl/cpc_xor_tree.sv
module cpc_xor_tree #(
  parameter int unsigned IN_W = 11
) (
  input  logic [IN_W-1:0] bits_i,
  output logic            sum_o
);
  localparam int unsigned LEAVES = 1 << $clog2(IN_W);

  logic [2*LEAVES-1:1] node;

  for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
    if (i < IN_W) begin : g_used
      assign node[LEAVES+i] = bits_i[i];
    end else begin : g_pad
      assign node[LEAVES+i] = 1'b0;
    end
  end

  for (genvar j = 1; j < LEAVES; j++) begin : g_node
    assign node[j] = node[2*j] ^ node[2*j+1];
  end

  assign sum_o = node[1];
endmodule

// File: rtl/cpc_err_reg.sv
module cpc_err_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cap_en_ni,
  input  logic ok_i,
  output logic err_no
);
  logic ok_q, ok_d;

  always_comb begin
    ok_d = ok_q;
    if (!cap_en_ni) begin
      ok_d = ok_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ok_q <= 1'b1;
    end else begin
      ok_q <= ok_d;
    end
  end

  assign err_no = ok_q;

  AST_ERR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_en_ni |=> $stable(err_no)); // R8
endmodule

// File: rtl/cascade_parity_chk.sv
module cascade_parity_chk
  import cpc_pkg::*;
#(
  parameter int unsigned DATA_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              par_i,
  input  logic              cap_en_ni,
  input  logic              sum_oe_ni,
  input  logic              par_io_i,
  output logic              par_io_o,
  output logic              par_io_oe,
  output logic              err_no
);
  localparam int unsigned TREE_W = DATA_W + 1;

  cpc_mode_e         mode;
  logic [DATA_W-1:0] word_q;
  logic              part_sum;
  logic              verdict_ok;

  cpc_word_pipe #(.WORD_W(DATA_W)) u_pipe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .word_i (data_i),
    .word_o (word_q)
  );

  cpc_xor_tree #(.IN_W(TREE_W)) u_tree (
    .bits_i ({par_i, word_q}),
    .sum_o  (part_sum)
  );

  always_comb begin
    mode = sum_oe_ni ? MODE_CHECK : MODE_EXPORT;
    if (mode == MODE_EXPORT) begin
      verdict_ok = 1'b1;
    end else begin
      verdict_ok = ~(part_sum ^ par_io_i);
    end
  end

  cpc_err_reg u_err (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cap_en_ni (cap_en_ni),
    .ok_i      (verdict_ok),
    .err_no    (err_no)
  );

  assign par_io_o  = part_sum;
  assign par_io_oe = (mode == MODE_EXPORT);

  AST_CHECK_VERDICT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sum_oe_ni && !cap_en_ni) |=> (err_no == ~($past(par_io_o) ^ $past(par_io_i)))); // R7
  AST_EXPORT_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sum_oe_ni && !cap_en_ni) |=> err_no); // R9
endmodule

// File: tb/cascade_parity_chk_tb.sv
module cascade_parity_chk_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic [9:0] data_i;
  logic       par_i, cap_en_ni, sum_oe_ni, par_io_i;
  logic       par_io_o, par_io_oe, err_no;

  int tests  = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk_i = ~clk_i;

  cascade_parity_chk #(.DATA_W(10)) dut_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .data_i    (data_i),
    .par_i     (par_i),
    .cap_en_ni (cap_en_ni),
    .sum_oe_ni (sum_oe_ni),
    .par_io_i  (par_io_i),
    .par_io_o  (par_io_o),
    .par_io_oe (par_io_oe),
    .err_no    (err_no)
  );

  task automatic check(input logic got, input logic exp, input string req);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b (t=%0t)", req, got, exp, $time);
    end
  endtask

  // Word cycle then parity cycle; data_i carries a parity-flipped word
  // during the parity cycle. Ends just before the capture edge (+1).
  task automatic present(input logic [9:0] w, input logic p, input logic line,
                         input logic oe_n, input logic cap_n);
    @(negedge clk_i);
    data_i = w; cap_en_ni = 1'b1; sum_oe_ni = oe_n; par_io_i = line; par_i = 1'b0;
    @(negedge clk_i);
    data_i = w ^ 10'h001; par_i = p; cap_en_ni = cap_n;
    #1;
  endtask

  task automatic settle();
    @(negedge clk_i);
    cap_en_ni = 1'b1;
    #1;
  endtask

  initial begin
    rst_ni = 1'b0; data_i = '0; par_i = 1'b0; cap_en_ni = 1'b1;
    sum_oe_ni = 1'b1; par_io_i = 1'b0;
    repeat (3) @(negedge clk_i);
    check(err_no, 1'b1, "R10 reset err");
    sum_oe_ni = 1'b0; par_i = 1'b1;
    #1;
    check(par_io_o, 1'b1, "R10 cleared word, sum follows par");
    rst_ni = 1'b1;
    sum_oe_ni = 1'b1;

    // Even and odd parity sweeps, every word, both parity bits
    for (int s = 0; s < 2; s++) begin
      for (int p = 0; p < 2; p++) begin
        for (int w = 0; w < 1024; w++) begin
          logic exp_err;
          present(w[9:0], p[0], s[0], 1'b1, 1'b0);
          check(par_io_oe, 1'b0, "R6 no drive");
          settle();
          exp_err = (^w[9:0]) ^ p[0] ^ s[0];
          check(err_no, ~exp_err, s == 0 ? "R1/R3 even" : "R1/R4 odd");
        end
      end
    end

    // Export sweep
    for (int w = 0; w < 1024; w++) begin
      logic p;
      p = w[3] ^ w[7];
      present(w[9:0], p, 1'b0, 1'b0, 1'b0);
      check(par_io_oe, 1'b1, "R5 drive on");
      check(par_io_o, (^w[9:0]) ^ p, "R5 partial sum");
      settle();
      if (w % 64 == 0) check(err_no, 1'b1, "R9 export no error");
    end

    // R9: a pending error is overwritten by an export capture
    present(10'h001, 1'b0, 1'b0, 1'b1, 1'b0); settle();
    check(err_no, 1'b0, "R9 setup error");
    present(10'h001, 1'b0, 1'b0, 1'b0, 1'b0); settle();
    check(err_no, 1'b1, "R9 export clears");

    // R2: verdict not visible before the capture edge
    present(10'h003, 1'b0, 1'b0, 1'b1, 1'b0);
    check(err_no, 1'b1, "R2 good verdict");
    settle();
    present(10'h007, 1'b0, 1'b0, 1'b1, 1'b0);
    check(err_no, 1'b1, "R2 before edge");
    settle();
    check(err_no, 1'b0, "R2 after edge");

    // R8: hold error while capture disabled, then clear
    present(10'h000, 1'b0, 1'b0, 1'b1, 1'b1); settle();
    check(err_no, 1'b0, "R8 hold error");
    present(10'h000, 1'b0, 1'b0, 1'b1, 1'b0); settle();
    check(err_no, 1'b1, "R8 cleared");
    present(10'h3FF, 1'b1, 1'b0, 1'b1, 1'b1); settle();
    check(err_no, 1'b1, "R8 hold ok");

    // R7: chained pair, upstream sum computed here
    for (int k = 0; k < 64; k++) begin
      logic [9:0] up_w, lo_w;
      logic up_p, lo_p, up_sum;
      up_w = 10'(k * 37 + 5);
      lo_w = 10'(k * 91 + 3);
      up_p = k[0];
      lo_p = k[2];
      up_sum = (^up_w) ^ up_p;
      present(lo_w, lo_p, up_sum, 1'b1, 1'b0); settle();
      check(err_no, ~(up_sum ^ (^lo_w) ^ lo_p), "R7 chained verdict");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule